// File: doc/BRIEF.md
# Serial CRC-8 Generator and Residue Checker

This block computes an 8-bit cyclic redundancy check over a stream that arrives one bit at a time from a single-wire serial bus, using the generator polynomial x^8 + x^5 + x^4 + 1. It suits two jobs. One is validating a 64-bit device identifier: a one-byte family code in the low byte, a 48-bit serial number, and a top byte that holds the CRC of the lower 56 bits. The other is validating a 9-byte data block whose last byte is the CRC of the first eight.

The register starts from all zeros, so software or the bus controller pulses the clear input before each message. Each bit strobe folds one data bit into the register, least significant bit of the first byte first. After the data bits the register holds the computed CRC. When the received CRC byte is shifted through as well, a correct message leaves the register at zero, and the zero flag reports this. A byte port folds a whole byte in one clock cycle. The result is the same as eight bit strobes given LSB first.

Top module: `crc8_serial_check`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the register is cleared, so `crc_out` is 8'h00 after that edge.
- R2: `clr` high at a clock edge sets `crc_out` to 8'h00 after that edge. It takes priority over `bit_vld` and `byte_vld` in the same cycle.
- R3: With `clr` and `byte_vld` low and `bit_vld` high, one bit is folded in. Let f = crc_out[0] XOR bit_in. The next value is crc_out shifted right by one, XORed with 8'h8C when f is 1. So bit 7 of the new value equals f.
- R4: With `clr`, `bit_vld` and `byte_vld` all low, `crc_out` keeps its value whatever `bit_in` and `byte_in` carry.
- R5: With `clr` low and `byte_vld` high, `byte_in` is folded in during a single cycle. The result equals eight R3 steps taken from byte_in[0] up to byte_in[7]. Over the ASCII bytes "123456789" starting from zero, the result is 8'hA1.
- R6: When `byte_vld` and `bit_vld` are high together without `clr`, only the byte is folded in and `bit_in` has no effect.
- R7: `crc_zero` is high in exactly the cycles in which `crc_out` is 8'h00. It follows the register without a cycle of delay.
- R8: Feed the 56 low bits of an identifier (family code 8'h10 in bits 7:0) through `bit_in`. `crc_out` then equals the CRC of those bits. Shifting that CRC through as the top byte leaves `crc_zero` high. A single flipped identifier bit leaves it low.
- R9: Feed an 8-byte block through `byte_in`. `crc_out` then equals its CRC. Sending that CRC as byte 9 leaves `crc_zero` high. A single flipped bit in any data byte leaves it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clears the register before a new message |
| bit_vld | input | 1 | Strobe: fold `bit_in` into the register |
| bit_in | input | 1 | Serial data bit |
| byte_vld | input | 1 | Strobe: fold all of `byte_in` into the register |
| byte_in | input | BYTE_W (8) | Data byte, bit 0 consumed first |
| crc_out | output | 8 | Running CRC register |
| crc_zero | output | 1 | High when the register holds zero |

## Verification
All state lives in the single 8-bit register, and `crc_out` exposes that register directly. A wrong feedback tap or a wrong bit order therefore shows on the port in the cycle after the offending strobe. The bench catches this by comparing every strobe against an arithmetic model, starting from many register states. A fault in the byte path that only touches some bit positions shows in the byte sweep on the first byte that exercises it. A priority error between the strobes shows one cycle after the collision. A fault that only breaks the zero residue shows after the final CRC byte of a frame. This is nine or sixty-four strobes after the clear, depending on the path.

// File: rtl/crc8_pkg.sv
package crc8_pkg;

    localparam int CRC_W = 8;
    // x^8 + x^5 + x^4 + 1, bit-reversed for a right-shifting register
    localparam logic [CRC_W-1:0] POLY_REFL = 8'h8C;

    typedef logic [CRC_W-1:0] crc_t;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_CLEAR = 2'd1,
        UPD_BIT   = 2'd2,
        UPD_BYTE  = 2'd3
    } upd_e;

    function automatic crc_t crc_bit_step(input crc_t cur, input logic din);
        logic fb;
        crc_t sh;
        fb = cur[0] ^ din;
        sh = cur >> 1;
        return fb ? (sh ^ POLY_REFL) : sh;
    endfunction

endpackage

// File: rtl/crc8_step_chain.sv
module crc8_step_chain
    import crc8_pkg::*;
#(
    parameter int N = 8
) (
    input  crc_t           crc_in,
    input  logic [N-1:0]   data,
    output crc_t           crc_o
);

    logic [N:0][CRC_W-1:0] stage;

    assign stage[0] = crc_in;

    generate
        for (genvar i = 0; i < N; i++) begin : g_step
            assign stage[i+1] = crc_bit_step(stage[i], data[i]);
        end
    endgenerate

    assign crc_o = stage[N];

endmodule

// File: rtl/crc8_update_sel.sv
module crc8_update_sel
    import crc8_pkg::*;
(
    input  logic clr,
    input  logic bit_vld,
    input  logic byte_vld,
    output upd_e sel
);

    always_comb begin
        if (clr)
            sel = UPD_CLEAR;
        else if (byte_vld)
            sel = UPD_BYTE;
        else if (bit_vld)
            sel = UPD_BIT;
        else
            sel = UPD_HOLD;
    end

endmodule

// File: rtl/crc8_state_reg.sv
module crc8_state_reg
    import crc8_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  upd_e sel,
    input  crc_t bit_nxt,
    input  crc_t byte_nxt,
    output crc_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (sel)
                UPD_CLEAR: q <= '0;
                UPD_BIT:   q <= bit_nxt;
                UPD_BYTE:  q <= byte_nxt;
                default:   q <= q;
            endcase
        end
    end

endmodule

// File: rtl/crc8_serial_check.sv
module crc8_serial_check
    import crc8_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CRC_W-1:0]  crc_out,
    output logic              crc_zero
);

    upd_e sel;
    crc_t crc_q;
    crc_t bit_nxt;
    crc_t byte_nxt;

    crc8_update_sel u_sel (
        .clr      (clr),
        .bit_vld  (bit_vld),
        .byte_vld (byte_vld),
        .sel      (sel)
    );

    crc8_step_chain #(.N(1)) u_bit_chain (
        .crc_in (crc_q),
        .data   (bit_in),
        .crc_o  (bit_nxt)
    );

    crc8_step_chain #(.N(BYTE_W)) u_byte_chain (
        .crc_in (crc_q),
        .data   (byte_in),
        .crc_o  (byte_nxt)
    );

    crc8_state_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .bit_nxt  (bit_nxt),
        .byte_nxt (byte_nxt),
        .q        (crc_q)
    );

    assign crc_out  = crc_q;
    assign crc_zero = (crc_q == '0);

endmodule

// File: rtl/crc8_serial_check_sva.sv
module crc8_serial_check_sva
    import crc8_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              clr,
    input logic              bit_vld,
    input logic              bit_in,
    input logic              byte_vld,
    input logic [BYTE_W-1:0] byte_in,
    input logic [CRC_W-1:0]  crc_out,
    input logic              crc_zero
);

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (crc_out == '0));

    assert_clear_wins_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc_out == '0));

    assert_bit_feedback_R3: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && !clr && !byte_vld) |=> (crc_out[7] == ($past(crc_out[0]) ^ $past(bit_in))));

    assert_bit_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && !clr && !byte_vld) |=>
            (crc_out == crc_bit_step($past(crc_out), $past(bit_in))));

    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr && !bit_vld && !byte_vld) |=> $stable(crc_out));

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
        crc_zero |-> ($countones(crc_out) == 0));

    assert_nonzero_flag_R7: assert property (@(posedge clk) disable iff (rst)
        !crc_zero |-> ($countones(crc_out) != 0));

endmodule

bind crc8_serial_check crc8_serial_check_sva #(.BYTE_W(BYTE_W)) u_sva (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .byte_vld (byte_vld),
    .byte_in  (byte_in),
    .crc_out  (crc_out),
    .crc_zero (crc_zero)
);

// File: tb/crc8_serial_check_test.sv
module crc8_serial_check_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic [7:0] crc_out;
    logic       crc_zero;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc8_serial_check uut (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .crc_out  (crc_out),
        .crc_zero (crc_zero)
    );

    // Reference model written from the requirement text
    function automatic logic [7:0] ref_bit(input logic [7:0] c, input logic d);
        logic [7:0] n;
        n = {1'b0, c[7:1]};
        if (c[0] != d) n = n ^ 8'h8C;
        return n;
    endfunction

    function automatic logic [7:0] ref_byte(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c;
        for (int i = 0; i < 8; i++) r = ref_bit(r, b[i]);
        return r;
    endfunction

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes; returns after the update is visible
    task automatic drive(input logic c, input logic bv, input logic bi,
                         input logic yv, input logic [7:0] yi);
        @(negedge clk);
        clr = c; bit_vld = bv; bit_in = bi; byte_vld = yv; byte_in = yi;
        @(negedge clk);
        clr = 1'b0; bit_vld = 1'b0; byte_vld = 1'b0;
    endtask

    task automatic do_clr();
        drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic do_bit(input logic d);
        drive(1'b0, 1'b1, d, 1'b0, 8'h00);
    endtask

    task automatic do_byte(input logic [7:0] b);
        drive(1'b0, 1'b0, 1'b0, 1'b1, b);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] exp;
        logic [7:0] st;
        logic [63:0] id;
        logic [7:0] blk [0:7];

        repeat (3) @(negedge clk);
        // R1: reset state
        chk8("R1 reset value", crc_out, 8'h00);
        chk1("R7 zero flag at reset", crc_zero, 1'b1);
        @(negedge clk);
        rst = 1'b0;

        // R3: single bit step from every reachable state
        for (int b = 0; b < 256; b++) begin
            for (int d = 0; d < 2; d++) begin
                do_clr();
                do_byte(b[7:0]);
                st = ref_byte(8'h00, b[7:0]);
                do_bit(d[0]);
                chk8("R3 bit step", crc_out, ref_bit(st, d[0]));
                chk1("R7 zero flag follows", crc_zero, ref_bit(st, d[0]) == 8'h00);
            end
        end

        // R5: byte pairs sweep
        for (int b1 = 0; b1 < 256; b1++) begin
            for (int b2 = 0; b2 < 256; b2 += 17) begin
                do_clr();
                do_byte(b1[7:0]);
                do_byte(b2[7:0]);
                chk8("R5 byte pair", crc_out, ref_byte(ref_byte(8'h00, b1[7:0]), b2[7:0]));
            end
        end

        // R5: well-known check string "123456789"
        do_clr();
        for (int k = 1; k <= 9; k++) do_byte(8'h30 + k[7:0]);
        chk8("R5 check string", crc_out, 8'hA1);

        // R4: idle cycles with changing data leave the register alone
        do_clr();
        do_byte(8'h5A);
        exp = ref_byte(8'h00, 8'h5A);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            bit_in = k[0];
            byte_in = 8'hC3 ^ k[7:0];
            @(negedge clk);
            chk8("R4 hold when idle", crc_out, exp);
        end

        // R6: byte strobe beats bit strobe
        for (int b = 0; b < 256; b += 5) begin
            do_clr();
            do_byte(8'h77);
            st = ref_byte(8'h00, 8'h77);
            drive(1'b0, 1'b1, b[0] ^ st[0], 1'b1, b[7:0]);
            chk8("R6 byte priority", crc_out, ref_byte(st, b[7:0]));
        end

        // R2: clear beats both strobes
        do_byte(8'h12);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'hFF);
        chk8("R2 clear priority", crc_out, 8'h00);
        chk1("R2 zero flag after clear", crc_zero, 1'b1);

        // R8: identifiers through the bit path
        for (int k = 0; k < 12; k++) begin
            id[7:0]  = 8'h10;
            id[55:8] = {k[7:0] * 8'h1D, 8'hA5 ^ k[7:0], k[7:0] + 8'h3C,
                        8'h01 << (k % 8), ~k[7:0], k[7:0] * 8'h47};
            exp = 8'h00;
            for (int i = 0; i < 56; i++) exp = ref_bit(exp, id[i]);
            id[63:56] = exp;
            do_clr();
            for (int i = 0; i < 56; i++) do_bit(id[i]);
            chk8("R8 identifier crc", crc_out, exp);
            for (int i = 56; i < 64; i++) do_bit(id[i]);
            chk1("R8 identifier residue zero", crc_zero, 1'b1);
            do_clr();
            for (int i = 0; i < 64; i++) do_bit(id[i] ^ (i == (k * 5) % 56));
            chk1("R8 flipped identifier bit", crc_zero, 1'b0);
        end

        // R9: 9-byte blocks through the byte path
        for (int k = 0; k < 16; k++) begin
            exp = 8'h00;
            for (int j = 0; j < 8; j++) begin
                blk[j] = (k[7:0] * 8'h31) ^ (j[7:0] * 8'h5B) ^ 8'h0F;
                exp = ref_byte(exp, blk[j]);
            end
            do_clr();
            for (int j = 0; j < 8; j++) do_byte(blk[j]);
            chk8("R9 block crc", crc_out, exp);
            do_byte(exp);
            chk1("R9 block residue zero", crc_zero, 1'b1);
            chk8("R9 block residue value", crc_out, 8'h00);
            do_clr();
            for (int j = 0; j < 8; j++)
                do_byte(blk[j] ^ ((j == k % 8) ? (8'h01 << (k % 8)) : 8'h00));
            do_byte(exp);
            chk1("R9 corrupted block", crc_zero, 1'b0);
        end

        // R1: reset in mid-message
        do_byte(8'hE7);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk8("R1 reset mid message", crc_out, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule